// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This block sits at the end of a pixel pipeline and narrows 10-bit red, green and blue components to 8 or 6 significant bits. Before the low bits are dropped, it adds a small pseudo-random value to each component. This hides the contour bands that plain truncation leaves in smooth gradients. The random values come from three 28-bit linear feedback shift registers, one per channel. Each register loads its own programmable seed. Each one advances once for every valid pixel and holds while the input is idle.

A mode input sets the feedback taps. In shared mode all three generators use the polynomial x^28 + x^3 + 1. In per-channel mode red keeps that polynomial, green uses x^28 + x^9 + 1 and blue uses x^28 + x^13 + 1. A frame-random option makes each frame start reload the generators. The reload value is the seed XORed with a 4-bit frame count that wraps after 15, so successive frames get different noise. Without this option the generators load their seeds only at reset. The depth code picks the output precision. The code for 10 bits, and the spare code, pass pixels through untouched. With dithering disabled, pixels are truncated without noise and frame-start reloads stop.

Top module: `spdith_reducer`

## Requirements
- R1: While reset is held and after it is released, before any pixel, `out_valid` is 0 and all three output components are 0. Reset is synchronous and active low, and loads each generator with its seed.
- R2: `out_valid` rises exactly one clock after a cycle with `pix_valid` high and is low after a cycle with `pix_valid` low. The output components belong to the pixel accepted on that earlier edge.
- R3: With `cfg_depth` = 0 (6-bit output) and dithering enabled, each output is min(pixel + state[3:0], 1023) with bits [3:0] cleared. Here state is that channel's generator value used for the pixel.
- R4: With `cfg_depth` = 1 (8-bit output) and dithering enabled, each output is min(pixel + state[1:0], 1023) with bits [1:0] cleared.
- R5: The sum never wraps. A code of 1023 gives 1008 at depth 0 and 1020 at depth 1, whatever the noise.
- R6: Each generator shifts toward its MSB, and the new bit 0 is the XOR of state bits 27 and (k-1) for polynomial x^28 + x^k + 1. With `cfg_per_channel` = 0, all three channels use k = 3.
- R7: With `cfg_per_channel` = 1, red uses k = 3, green k = 9 and blue k = 13.
- R8: A generator advances exactly once per valid pixel and holds its value on cycles with `pix_valid` low.
- R9: With `cfg_frame_random` = 1 and dithering active, a `frame_start` pulse reloads every generator with seed XOR the frame count in bits [3:0]. A pixel in the same cycle uses the reloaded value. The count is 0 after reset, steps by one per frame start, wraps from 15 to 0, and is cleared while frame-random is inactive.
- R10: With `cfg_frame_random` = 0, `frame_start` has no effect on the noise sequence.
- R11: With `cfg_dither_en` = 0 and depth 0 or 1, outputs are the pixel with the dropped bits cleared and no noise added. `frame_start` causes no reload even when `cfg_frame_random` = 1.
- R12: With `cfg_depth` = 2 or 3, each output equals its input pixel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_r | input | 10 | Red input component |
| pix_g | input | 10 | Green input component |
| pix_b | input | 10 | Blue input component |
| cfg_dither_en | input | 1 | Enables noise addition |
| cfg_depth | input | 2 | 0: 6-bit, 1: 8-bit, 2/3: pass-through |
| cfg_per_channel | input | 1 | 0: shared taps, 1: distinct taps per channel |
| cfg_frame_random | input | 1 | Reload generators at each frame start |
| seed_r | input | 28 | Red generator seed |
| seed_g | input | 28 | Green generator seed |
| seed_b | input | 28 | Blue generator seed |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 10 | Red output component |
| out_g | output | 10 | Green output component |
| out_b | output | 10 | Blue output component |

## Verification
Every result of this block is due at the first rising edge after the pixel is presented. That covers the valid flag, the dithered or truncated value and the effect of a frame-start reload in that same cycle. A generator step shows up only in the next valid pixel's noise. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It keeps its own copy of the three generators and the frame count, and updates that copy once per edge from the inputs it drove. Each sample is therefore compared with the value due in that exact cycle, and idle cycles check that the sequence holds.

// File: rtl/spdith_pkg.sv
package spdith_pkg;
   localparam int SPD_CHANNELS = 3;
   localparam int SPD_DEPTH6   = 0;
   localparam int SPD_DEPTH8   = 1;
endpackage

// File: rtl/spdith_lfsr.sv
module spdith_lfsr #(
   parameter int LW         = 28,
   parameter int NW         = 4,
   parameter int TAP_SHARED = 3,
   parameter int TAP_OWN    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] seed,
   input  logic          per_chan,
   input  logic          load,
   input  logic [LW-1:0] load_val,
   input  logic          adv,
   output logic [NW-1:0] noise
);
   generate
      if (TAP_SHARED < 1 || TAP_SHARED >= LW || TAP_OWN < 1 || TAP_OWN >= LW) begin : g_bad_tap
         $error("spdith_lfsr: tap position outside register");
      end
      if (NW > LW) begin : g_bad_nw
         $error("spdith_lfsr: noise wider than register");
      end
   endgenerate

   logic [LW-1:0] state, src, nxt;
   logic          fb;

   always_comb begin
      src = load ? load_val : state;
      fb  = src[LW-1] ^ (per_chan ? src[TAP_OWN-1] : src[TAP_SHARED-1]);
      nxt = adv ? {src[LW-2:0], fb} : src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= seed;
      else        state <= nxt;
   end

   assign noise = src[NW-1:0];

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(state));
   p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> state[LW-1:1] == $past(state[LW-2:0]));
endmodule

// File: rtl/spdith_frame_ctr.sv
module spdith_frame_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          tick,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] MAXV = {CW{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!enable)  cnt <= '0;
      else if (tick)     cnt <= (cnt == MAXV) ? '0 : cnt + 1'b1;
   end

   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && tick && cnt == MAXV) |=> cnt == '0);
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> cnt == '0);
endmodule

// File: rtl/spdith_quant.sv
module spdith_quant #(
   parameter int IN_W = 10
) (
   input  logic [IN_W-1:0] pix,
   input  logic [IN_W-7:0] noise,
   input  logic            dith_on,
   input  logic [1:0]      depth,
   output logic [IN_W-1:0] q
);
   localparam int D6 = IN_W - 6;
   localparam int D8 = IN_W - 8;

   logic [IN_W:0]   sum;
   logic [IN_W-1:0] n, mask, sat;

   always_comb begin
      n    = '0;
      mask = '1;
      case (depth)
         2'd0: begin
            mask = {{6{1'b1}}, {D6{1'b0}}};
            if (dith_on) n = IN_W'(noise);
         end
         2'd1: begin
            mask = {{8{1'b1}}, {D8{1'b0}}};
            if (dith_on) n = IN_W'(noise[D8-1:0]);
         end
         default: ;
      endcase
      sum = {1'b0, pix} + {1'b0, n};
      sat = sum[IN_W] ? '1 : sum[IN_W-1:0];
      q   = sat & mask;
   end

   always_comb begin
      p_no_wrap_r5: assert (q >= (pix & mask));
      if (depth == 2'd0) p_low_zero_r3: assert (q[D6-1:0] == '0);
   end
endmodule

// File: rtl/spdith_reducer.sv
module spdith_reducer #(
   parameter int IN_W  = 10,
   parameter int LW    = 28,
   parameter int CW    = 4,
   parameter int TAP_R = 3,
   parameter int TAP_G = 9,
   parameter int TAP_B = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start,
   input  logic            pix_valid,
   input  logic [IN_W-1:0] pix_r,
   input  logic [IN_W-1:0] pix_g,
   input  logic [IN_W-1:0] pix_b,
   input  logic            cfg_dither_en,
   input  logic [1:0]      cfg_depth,
   input  logic            cfg_per_channel,
   input  logic            cfg_frame_random,
   input  logic [LW-1:0]   seed_r,
   input  logic [LW-1:0]   seed_g,
   input  logic [LW-1:0]   seed_b,
   output logic            out_valid,
   output logic [IN_W-1:0] out_r,
   output logic [IN_W-1:0] out_g,
   output logic [IN_W-1:0] out_b
);
   import spdith_pkg::*;

   localparam int NW = IN_W - 6;

   generate
      if (IN_W < 9 || IN_W > 16) begin : g_bad_width
         $error("spdith_reducer: IN_W must be 9..16");
      end
      if (CW >= LW || NW > LW) begin : g_bad_lfsr
         $error("spdith_reducer: LFSR too short");
      end
   endgenerate

   logic            dith_on, fr_on, reload;
   logic [CW-1:0]   frame_cnt;
   logic [IN_W-1:0] pix_a  [SPD_CHANNELS];
   logic [LW-1:0]   seed_a [SPD_CHANNELS];
   logic [IN_W-1:0] q_a    [SPD_CHANNELS];
   logic [IN_W-1:0] out_a  [SPD_CHANNELS];

   assign dith_on = cfg_dither_en && (cfg_depth == 2'(SPD_DEPTH6) || cfg_depth == 2'(SPD_DEPTH8));
   assign fr_on   = dith_on && cfg_frame_random;
   assign reload  = fr_on && frame_start;

   assign pix_a[0]  = pix_r;
   assign pix_a[1]  = pix_g;
   assign pix_a[2]  = pix_b;
   assign seed_a[0] = seed_r;
   assign seed_a[1] = seed_g;
   assign seed_a[2] = seed_b;

   spdith_frame_ctr #(.CW(CW)) u_fctr (
      .clk(clk), .rst_n(rst_n), .enable(fr_on), .tick(frame_start), .cnt(frame_cnt)
   );

   generate
      for (genvar c = 0; c < SPD_CHANNELS; c++) begin : g_chan
         localparam int TAP_SEL = (c == 0) ? TAP_R : (c == 1) ? TAP_G : TAP_B;
         logic [NW-1:0] noise;

         spdith_lfsr #(.LW(LW), .NW(NW), .TAP_SHARED(TAP_R), .TAP_OWN(TAP_SEL)) u_lfsr (
            .clk(clk), .rst_n(rst_n), .seed(seed_a[c]), .per_chan(cfg_per_channel),
            .load(reload), .load_val(seed_a[c] ^ LW'(frame_cnt)), .adv(pix_valid),
            .noise(noise)
         );

         spdith_quant #(.IN_W(IN_W)) u_quant (
            .pix(pix_a[c]), .noise(noise), .dith_on(dith_on), .depth(cfg_depth), .q(q_a[c])
         );

         always_ff @(posedge clk) begin
            if (!rst_n)         out_a[c] <= '0;
            else if (pix_valid) out_a[c] <= q_a[c];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= pix_valid;
   end

   assign out_r = out_a[0];
   assign out_g = out_a[1];
   assign out_b = out_a[2];

   p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);
   p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);
   p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && cfg_depth[1]) |=> (out_r == $past(pix_r) && out_b == $past(pix_b)));
endmodule

// File: tb/test_spdith_reducer.sv
module test_spdith_reducer;
   logic       clk = 1'b0;
   logic       rst_n, frame_start, pix_valid;
   logic [9:0] pix_r, pix_g, pix_b;
   logic       cfg_dither_en, cfg_per_channel, cfg_frame_random;
   logic [1:0] cfg_depth;
   logic [27:0] seed_r, seed_g, seed_b;
   logic       out_valid;
   logic [9:0] out_r, out_g, out_b;

   int checks = 0, failures = 0;
   logic [27:0] m [3];
   logic [3:0]  mcnt;

   always #2.5 clk = ~clk;

   spdith_reducer i_spdith_reducer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .cfg_dither_en(cfg_dither_en), .cfg_depth(cfg_depth),
      .cfg_per_channel(cfg_per_channel), .cfg_frame_random(cfg_frame_random),
      .seed_r(seed_r), .seed_g(seed_g), .seed_b(seed_b),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [27:0] seed_of(int c);
      return (c == 0) ? seed_r : (c == 1) ? seed_g : seed_b;
   endfunction

   function automatic logic [27:0] step(logic [27:0] s, int c);
      int k;
      k = (!cfg_per_channel || c == 0) ? 3 : (c == 1) ? 9 : 13;
      return {s[26:0], s[27] ^ s[k-1]};
   endfunction

   function automatic logic [9:0] expect_q(logic [9:0] p, logic [27:0] s);
      logic [10:0] sum;
      logic [9:0]  n;
      if (cfg_depth[1]) return p;
      n = 10'd0;
      if (cfg_dither_en) n = (cfg_depth == 2'd0) ? {6'd0, s[3:0]} : {8'd0, s[1:0]};
      sum = {1'b0, p} + {1'b0, n};
      if (sum > 11'd1023) sum = 11'd1023;
      return (cfg_depth == 2'd0) ? (sum[9:0] & 10'h3F0) : (sum[9:0] & 10'h3FC);
   endfunction

   // One clock: drive at the falling edge, sample 1 ns after the rising edge.
   task automatic cycle(logic v, logic fs, logic [9:0] r, logic [9:0] g, logic [9:0] b, string tag);
      logic [27:0] src [3];
      logic [9:0]  e [3];
      logic        fr_eff;
      @(negedge clk);
      pix_valid = v; frame_start = fs; pix_r = r; pix_g = g; pix_b = b;
      fr_eff = cfg_dither_en && !cfg_depth[1] && cfg_frame_random;
      for (int c = 0; c < 3; c++) begin
         src[c] = (fs && fr_eff) ? (seed_of(c) ^ {24'd0, mcnt}) : m[c];
         e[c]   = expect_q((c == 0) ? r : (c == 1) ? g : b, src[c]);
      end
      @(posedge clk);
      #1;
      for (int c = 0; c < 3; c++) m[c] = v ? step(src[c], c) : src[c];
      if (!fr_eff) mcnt = 4'd0;
      else if (fs) mcnt = mcnt + 4'd1;
      check("R2 out_valid", {31'd0, out_valid}, {31'd0, v});
      if (v) begin
         check({tag, " red"},   {22'd0, out_r}, {22'd0, e[0]});
         check({tag, " green"}, {22'd0, out_g}, {22'd0, e[1]});
         check({tag, " blue"},  {22'd0, out_b}, {22'd0, e[2]});
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; pix_valid = 1'b0; frame_start = 1'b0;
      pix_r = 10'd0; pix_g = 10'd0; pix_b = 10'd0;
      cfg_dither_en = 1'b1; cfg_depth = 2'd0; cfg_per_channel = 1'b0; cfg_frame_random = 1'b0;
      seed_r = 28'h1234567; seed_g = 28'h0ABCDEF; seed_b = 28'h5A5A5A5;
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
      check("R1 red in reset", {22'd0, out_r}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m[0] = seed_r; m[1] = seed_g; m[2] = seed_b; mcnt = 4'd0;
      @(posedge clk);
      #1;
      check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
      check("R1 green after reset", {22'd0, out_g}, 32'd0);
      check("R1 blue after reset", {22'd0, out_b}, 32'd0);
   endtask

   task automatic t_depth6;
      cfg_depth = 2'd0; cfg_per_channel = 1'b0;
      for (int i = 0; i < 12; i++)
         cycle(1'b1, 1'b0, 10'(i * 83), 10'(1000 - i * 61), 10'(i * 7 + 5), "R3 R6 depth6");
   endtask

   task automatic t_depth8;
      cfg_depth = 2'd1;
      for (int i = 0; i < 12; i++)
         cycle(1'b1, 1'b0, 10'(i * 29 + 3), 10'(512 + i), 10'(1021 - i * 40), "R4 depth8");
   endtask

   task automatic t_saturate;
      cfg_depth = 2'd0;
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 10'd1023, 10'd1023, 10'd1020, "R5 sat6");
      cfg_depth = 2'd1;
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 10'd1023, 10'd1022, 10'd1023, "R5 sat8");
   endtask

   task automatic t_per_channel;
      cfg_per_channel = 1'b1; cfg_depth = 2'd0;
      for (int i = 0; i < 40; i++)
         cycle(1'b1, 1'b0, 10'(i * 13), 10'(i * 13), 10'(i * 13), "R7 per-channel");
   endtask

   task automatic t_hold;
      for (int i = 0; i < 4; i++) begin
         cycle(1'b0, 1'b0, 10'd0, 10'd0, 10'd0, "R8 idle");
         cycle(1'b1, 1'b0, 10'd200, 10'd300, 10'd400, "R8 after idle");
      end
   endtask

   task automatic t_frame_random;
      cfg_frame_random = 1'b1; cfg_depth = 2'd0;
      for (int f = 0; f < 18; f++) begin
         cycle(1'b0, 1'b1, 10'd0, 10'd0, 10'd0, "R9 frame start");
         cycle(1'b1, 1'b0, 10'd100, 10'd100, 10'd100, "R9 first pixel");
         cycle(1'b1, 1'b0, 10'd101, 10'd102, 10'd103, "R9 second pixel");
      end
      cycle(1'b1, 1'b1, 10'd64, 10'd64, 10'd64, "R9 same-cycle reload");
      cycle(1'b1, 1'b0, 10'd64, 10'd64, 10'd64, "R9 after same-cycle reload");
      cfg_frame_random = 1'b0;
      cycle(1'b1, 1'b0, 10'd8, 10'd8, 10'd8, "R9 count clear");
      cfg_frame_random = 1'b1;
      cycle(1'b1, 1'b1, 10'd8, 10'd8, 10'd8, "R9 count from zero");
   endtask

   task automatic t_no_frame_random;
      cfg_frame_random = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cycle(1'b1, 1'b1, 10'd500, 10'd501, 10'd502, "R10 ignored start");
         cycle(1'b1, 1'b0, 10'd503, 10'd504, 10'd505, "R10 continue");
      end
   endtask

   task automatic t_disabled;
      cfg_dither_en = 1'b0; cfg_frame_random = 1'b1;
      cfg_depth = 2'd0;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 10'(i * 97 + 15), 10'd1023, 10'd7, "R11 trunc6");
      cfg_depth = 2'd1;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 10'(i * 97 + 3), 10'd1023, 10'd6, "R11 trunc8");
      cfg_dither_en = 1'b1; cfg_frame_random = 1'b0;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 10'd301, 10'd302, 10'd303, "R11 no reload seen");
   endtask

   task automatic t_passthrough;
      cfg_depth = 2'd2;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 10'(i * 211 + 1), 10'd1023, 10'd5, "R12 depth2");
      cfg_depth = 2'd3;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 10'(i * 199 + 9), 10'd2, 10'd1022, "R12 depth3");
      cfg_depth = 2'd0;
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 10'd600, 10'd601, 10'd602, "R8 after pass");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_depth6();
            t_depth8();
            t_saturate();
            t_per_channel();
            t_hold();
            t_frame_random();
            t_no_frame_random();
            t_disabled();
            t_passthrough();
         end
         begin
            repeat (20000) @(posedge clk);
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule